// File: doc/BRIEF.md
# Message-interrupt capability control sequencer

This block holds the writable control bits of a message-signalled interrupt capability: an enable bit and a function-wide mask bit. It also runs the actions that follow a configuration write to the byte that holds them. The rest of the capability (identifier, next pointer, table size, table offset and pending-array offset) is fixed by parameters and can only be read. The vector table itself and the sending of messages belong to a neighbouring table controller.

When a write touches the control byte and leaves the capability enabled, the block pulses a strobe that tells the legacy interrupt logic to drop its lines. If the same write also leaves the function unmasked, the block walks every implemented vector, one per cycle, from vector 0 upward. At each step it offers the vector index to the table controller. The table controller then sends any message that is pending and not masked. This flushes interrupts that were held back while the function was masked or disabled.

Top module: `msgirq_ctrl_seq`

## Requirements
- R1: After reset the enable output is 0, the function-mask output is 0, the deassert strobe is 0 and no scan is active.
- R2: Reading dword 0 returns the capability ID in bits 7:0 and the next pointer in bits 15:8. Bits 26:16 hold NUM_VEC-1, bits 29:27 are zero, bit 30 is the function mask and bit 31 is the enable. Writes never change the table-size bits.
- R3: A write that does not cover byte 3 of dword 0 (address not 0, or byte enable bit 3 clear) changes no state, raises no strobe and does not start, stop or restart a scan.
- R4: A write to dword 0 with byte enable bit 3 set loads the enable from data bit 31 and the mask from data bit 30, both visible from the next cycle. If the new enable is 1, the deassert strobe is high for exactly the next cycle. If the new enable is 0, there is no strobe and no scan.
- R5: A covering write that leaves the block enabled and masked raises the strobe but starts no scan.
- R6: A covering write that leaves the block enabled and unmasked starts a scan on the next cycle. The scan presents vectors 0, 1, ..., NUM_VEC-1 on consecutive cycles with the valid output high, then goes idle.
- R7: A covering write that arrives during a scan restarts the scan at vector 0 if the block is left enabled and unmasked. Otherwise the scan ends, and the valid output is low in the next cycle.
- R8: Dword 1 reads as the table offset with the bar index in bits 2:0. Dword 2 reads as the table offset plus 0x800 with the same bar index. Dword 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 2 | Dword index within the capability |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | 2 | Dword index to read |
| cfg_rd_data | output | 32 | Read data, combinational |
| cap_enable | output | 1 | Capability enable bit |
| func_mask | output | 1 | Function-wide mask bit |
| legacy_deassert | output | 1 | One-cycle request to drop legacy interrupt lines |
| scan_valid | output | 1 | A vector index is offered to the table controller (also busy) |
| scan_vec | output | 5 | Vector index being offered |

## Verification
The assertions check on every cycle that scan indices never exceed NUM_VEC-1 and only ever climb by one. They also check that a scan or a strobe only appears while the block is enabled (and, for a scan, unmasked), that the control bits hold still unless the previous cycle carried a covering write, and that the table-size field is constant. Only the bench's scenarios can show which actions a given write triggers, the full order of a walk, its restart and abort when the block is rewritten mid-scan, and the offset words. To do this it compares every cycle against a model built from the requirements, under random and directed writes.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
    localparam int VEC_W      = 5;
    localparam int CTRL_BYTE  = 3;
    localparam int EN_BIT     = 31;
    localparam int FMASK_BIT  = 30;
    localparam logic [31:0] PBA_GAP = 32'h0000_0800;

    typedef struct packed {
        logic en;
        logic fmask;
        logic pulse;
    } ctrl_t;

    typedef struct packed {
        logic             busy;
        logic [VEC_W-1:0] vec;
    } scan_t;
endpackage

// File: rtl/msgirq_ctrl_reg.sv
module msgirq_ctrl_reg
    import msgirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic        en,
    output logic        fmask,
    output logic        pulse,
    output logic        scan_start,
    output logic        scan_stop
);
    ctrl_t state_d, state_q;
    logic  covers;

    always_comb begin
        covers     = wr_en && (wr_addr == 2'd0) && wr_be[CTRL_BYTE];
        state_d    = state_q;
        state_d.pulse = 1'b0;
        scan_start = 1'b0;
        scan_stop  = 1'b0;
        if (covers) begin
            state_d.en    = wr_data[EN_BIT];
            state_d.fmask = wr_data[FMASK_BIT];
            state_d.pulse = wr_data[EN_BIT];
            if (wr_data[EN_BIT] && !wr_data[FMASK_BIT]) begin
                scan_start = 1'b1;
            end else begin
                scan_stop  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en    = state_q.en;
    assign fmask = state_q.fmask;
    assign pulse = state_q.pulse;
endmodule

// File: rtl/msgirq_scan_seq.sv
module msgirq_scan_seq
    import msgirq_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    output logic             busy,
    output logic [VEC_W-1:0] vec
);
    localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(NUM_VEC - 1);

    scan_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d.busy = 1'b1;
            state_d.vec  = '0;
        end else if (stop) begin
            state_d.busy = 1'b0;
            state_d.vec  = '0;
        end else if (state_q.busy) begin
            if (state_q.vec == LAST_VEC) begin
                state_d.busy = 1'b0;
                state_d.vec  = '0;
            end else begin
                state_d.vec  = state_q.vec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy = state_q.busy;
    assign vec  = state_q.vec;
endmodule

// File: rtl/msgirq_cfg_rdmux.sv
module msgirq_cfg_rdmux
    import msgirq_pkg::*;
#(
    parameter int          NUM_VEC    = 8,
    parameter logic [7:0]  CAP_ID     = 8'h11,
    parameter logic [7:0]  NEXT_PTR   = 8'h00,
    parameter logic [31:0] TBL_OFFSET = 32'h0000_1000,
    parameter logic [2:0]  BAR_IDX    = 3'd2
) (
    input  logic [1:0]  rd_addr,
    input  logic        en,
    input  logic        fmask,
    output logic [31:0] rd_data
);
    localparam logic [10:0] TSIZE    = 11'(NUM_VEC - 1);
    localparam logic [31:0] PBA_OFS  = TBL_OFFSET + PBA_GAP;
    localparam logic [31:0] TBL_WORD = {TBL_OFFSET[31:3], BAR_IDX};
    localparam logic [31:0] PBA_WORD = {PBA_OFS[31:3], BAR_IDX};

    always_comb begin
        case (rd_addr)
            2'd0:    rd_data = {en, fmask, 3'b000, TSIZE, NEXT_PTR, CAP_ID};
            2'd1:    rd_data = TBL_WORD;
            2'd2:    rd_data = PBA_WORD;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/msgirq_ctrl_seq.sv
module msgirq_ctrl_seq
    import msgirq_pkg::*;
#(
    parameter int          NUM_VEC    = 8,
    parameter logic [7:0]  CAP_ID     = 8'h11,
    parameter logic [7:0]  NEXT_PTR   = 8'h00,
    parameter logic [31:0] TBL_OFFSET = 32'h0000_1000,
    parameter logic [2:0]  BAR_IDX    = 3'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_wr_addr,
    input  logic [3:0]  cfg_wr_be,
    input  logic [31:0] cfg_wr_data,
    input  logic [1:0]  cfg_rd_addr,
    output logic [31:0] cfg_rd_data,
    output logic        cap_enable,
    output logic        func_mask,
    output logic        legacy_deassert,
    output logic        scan_valid,
    output logic [4:0]  scan_vec
);
    logic start_w, stop_w;

    msgirq_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_be      (cfg_wr_be),
        .wr_data    (cfg_wr_data),
        .en         (cap_enable),
        .fmask      (func_mask),
        .pulse      (legacy_deassert),
        .scan_start (start_w),
        .scan_stop  (stop_w)
    );

    msgirq_scan_seq #(.NUM_VEC(NUM_VEC)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_w),
        .stop  (stop_w),
        .busy  (scan_valid),
        .vec   (scan_vec)
    );

    msgirq_cfg_rdmux #(
        .NUM_VEC    (NUM_VEC),
        .CAP_ID     (CAP_ID),
        .NEXT_PTR   (NEXT_PTR),
        .TBL_OFFSET (TBL_OFFSET),
        .BAR_IDX    (BAR_IDX)
    ) u_rd (
        .rd_addr (cfg_rd_addr),
        .en      (cap_enable),
        .fmask   (func_mask),
        .rd_data (cfg_rd_data)
    );
endmodule

// File: rtl/msgirq_ctrl_seq_chk.sv
module msgirq_ctrl_seq_chk #(
    parameter int NUM_VEC = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [1:0]  cfg_wr_addr,
    input logic [3:0]  cfg_wr_be,
    input logic [1:0]  cfg_rd_addr,
    input logic [31:0] cfg_rd_data,
    input logic        cap_enable,
    input logic        func_mask,
    input logic        legacy_deassert,
    input logic        scan_valid,
    input logic [4:0]  scan_vec
);
    logic covering;
    assign covering = cfg_wr_en && (cfg_wr_addr == 2'd0) && cfg_wr_be[3];

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> (32'(scan_vec) < NUM_VEC)); // R6

    AST_VEC_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_vec != 5'd0) |-> ($past(scan_valid) && scan_vec == $past(scan_vec) + 5'd1)); // R6

    AST_SCAN_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> (cap_enable && !func_mask)); // R5

    AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_deassert |-> cap_enable); // R4

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(covering) |-> ($stable(cap_enable) && $stable(func_mask) && !legacy_deassert)); // R3

    AST_TSIZE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_addr == 2'd0) |-> (cfg_rd_data[26:16] == 11'(NUM_VEC - 1))); // R2
endmodule

bind msgirq_ctrl_seq msgirq_ctrl_seq_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr_en       (cfg_wr_en),
    .cfg_wr_addr     (cfg_wr_addr),
    .cfg_wr_be       (cfg_wr_be),
    .cfg_rd_addr     (cfg_rd_addr),
    .cfg_rd_data     (cfg_rd_data),
    .cap_enable      (cap_enable),
    .func_mask       (func_mask),
    .legacy_deassert (legacy_deassert),
    .scan_valid      (scan_valid),
    .scan_vec        (scan_vec)
);

// File: tb/msgirq_ctrl_seq_test.sv
`timescale 1ns/1ps
module msgirq_ctrl_seq_test;
    localparam int          NV   = 8;
    localparam logic [7:0]  CID  = 8'h11;
    localparam logic [7:0]  NXT  = 8'h00;
    localparam logic [31:0] TOFS = 32'h0000_1000;
    localparam logic [2:0]  BIDX = 3'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_addr = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        cap_enable, func_mask, legacy_deassert, scan_valid;
    logic [4:0]  scan_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic m_en = 0, m_fm = 0, m_pulse = 0, m_busy = 0;
    int   m_vec = 0;

    always #2 clk = ~clk;

    msgirq_ctrl_seq #(.NUM_VEC(NV), .CAP_ID(CID), .NEXT_PTR(NXT),
                      .TBL_OFFSET(TOFS), .BAR_IDX(BIDX)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .cap_enable(cap_enable), .func_mask(func_mask), .legacy_deassert(legacy_deassert),
        .scan_valid(scan_valid), .scan_vec(scan_vec)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        logic [31:0] p;
        p = TOFS + 32'h800;
        case (a)
            2'd0:    return {m_en, m_fm, 3'b000, 11'(NV - 1), NXT, CID};
            2'd1:    return {TOFS[31:3], BIDX};
            2'd2:    return {p[31:3], BIDX};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update(input logic w, input logic [1:0] a,
                                input logic [3:0] b, input logic [31:0] d);
        if (w && a == 2'd0 && b[3]) begin
            m_en = d[31];
            m_fm = d[30];
            m_pulse = d[31];
            m_busy = d[31] && !d[30];
            m_vec = 0;
        end else begin
            m_pulse = 0;
            if (m_busy) begin
                if (m_vec == NV - 1) begin m_busy = 0; m_vec = 0; end
                else m_vec = m_vec + 1;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4 cap_enable", 32'(cap_enable), 32'(m_en));
        chk("R4 func_mask", 32'(func_mask), 32'(m_fm));
        chk("R5 legacy_deassert", 32'(legacy_deassert), 32'(m_pulse));
        chk("R6 scan_valid", 32'(scan_valid), 32'(m_busy));
        if (m_busy) chk("R6 scan_vec", 32'(scan_vec), 32'(m_vec));
        chk(cfg_rd_addr == 2'd0 ? "R2 read" : "R8 read", cfg_rd_data, exp_read(cfg_rd_addr));
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic step(input logic w, input logic [1:0] a, input logic [3:0] b,
                        input logic [31:0] d, input logic [1:0] ra);
        cfg_wr_en = w; cfg_wr_addr = a; cfg_wr_be = b; cfg_wr_data = d; cfg_rd_addr = ra;
        @(posedge clk);
        model_update(w, a, b, d);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        compare_all();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 enable", 32'(cap_enable), 0);
        chk("R1 mask", 32'(func_mask), 0);
        chk("R1 strobe", 32'(legacy_deassert), 0);
        chk("R1 scan", 32'(scan_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R8: offset words and zero word
        step(0, 0, 0, 0, 2'd1);
        chk("R8 table word", cfg_rd_data, {TOFS[31:3], BIDX});
        step(0, 0, 0, 0, 2'd2);
        chk("R8 pending word", cfg_rd_data, 32'h0000_1802);
        step(0, 0, 0, 0, 2'd3);
        chk("R8 zero word", cfg_rd_data, 32'h0);

        // R5: enabled and masked
        step(1, 2'd0, 4'b1000, 32'hC000_0000, 2'd0);
        chk("R5 strobe", 32'(legacy_deassert), 1);
        chk("R5 no scan", 32'(scan_valid), 0);
        chk("R2 read ctrl", cfg_rd_data, 32'hC007_0011);

        // R6: full scan in order
        step(1, 2'd0, 4'b1000, 32'h8000_0000, 2'd0);
        for (int i = 0; i < NV; i++) begin
            chk("R6 walk valid", 32'(scan_valid), 1);
            chk("R6 walk index", 32'(scan_vec), i);
            step(0, 0, 0, 0, 2'd0);
        end
        chk("R6 walk ends", 32'(scan_valid), 0);

        // R3: non-covering writes during idle and during a scan
        step(1, 2'd0, 4'b0111, 32'hFFFF_FFFF, 2'd0);
        chk("R3 no strobe", 32'(legacy_deassert), 0);
        chk("R3 tsize kept", 32'(cfg_rd_data[26:16]), NV - 1);
        step(1, 2'd0, 4'b1000, 32'h8000_0000, 2'd0);
        step(0, 0, 0, 0, 2'd0);
        step(1, 2'd1, 4'b1111, 32'h4000_0000, 2'd0);
        chk("R3 scan unaffected", 32'(scan_vec), 2);

        // R7: restart and abort
        step(1, 2'd0, 4'b1000, 32'h8000_0000, 2'd0);
        chk("R7 restart at zero", 32'(scan_vec), 0);
        chk("R7 restart valid", 32'(scan_valid), 1);
        step(0, 0, 0, 0, 2'd0);
        step(1, 2'd0, 4'b1000, 32'h0000_0000, 2'd0);
        chk("R7 abort", 32'(scan_valid), 0);
        chk("R4 disabled no strobe", 32'(legacy_deassert), 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r, d;
            logic w;
            logic [1:0] a;
            logic [3:0] b;
            r = $urandom;
            d = $urandom;
            w = (r[3:0] < 4'd2);
            a = r[4] ? 2'd0 : r[6:5];
            b = r[7] ? (r[11:8] | 4'b1000) : r[11:8];
            step(w, a, b, d, r[13:12]);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule